// File: doc/BRIEF.md
# Two-Bundle In-Order Dispersal Unit

This block feeds a wide in-order core. Each cycle it looks at a window of up to two fetched bundles, six instruction slots in all. It hands as many of them as it can to a fixed set of nine typed issue ports. Every bundle carries a 5-bit template, which gives the unit type of each of its three slots and an optional group-stop mark after one of them.

Slots are visited strictly in program order. An instruction is placed on the lowest free port of its type. Selection ends at the first instruction that cannot be placed, or right after an instruction that carries a stop mark. Anything not placed stays in the window and is retried next cycle. A bundle leaves the window once its third instruction has been issued. The unit reports how many bundles left in each cycle, and the fetch side uses that count to advance.

A taken-branch input throws away whatever has not issued yet. Bundles enter through a valid/ready pair.

Top module: `bundle_disperser`

## Requirements
- R1: After reset, no issue port is valid, consumed_o is 0 and in_ready_o is 1.
- R2: Template bits [4:2] select the slot types (slot0,slot1,slot2): 0=M,I,I 1=M,M,I 2=M,F,I 3=M,I,B 4=M,B,B 5=B,B,B 6=M,M,F. Each placed instruction goes to the lowest free port of its type. Port indices are I:0-1, F:2-3, M:4-5, B:6-8. The port carries the payload of slot s (in_slots_i bits [16s+15:16s]) and origin = 3*window position + s, where window position 0 is the oldest bundle.
- R3: When every port of an instruction's type is taken in the current cycle, that instruction is held and issued in a later cycle.
- R4: Once an instruction is held, no later instruction in the window issues in that cycle, even if a port of its type is free.
- R5: Template bits [1:0] mark a group stop: 0 none, 1/2/3 after slot 0/1/2. No instruction after a stop issues in the same cycle. The next instruction issues in the following cycle.
- R6: At most six ports are valid in any cycle.
- R7: A bundle is consumed in the cycle its last instruction issues. consumed_o reports 0, 1 or 2 bundles, and the bundle behind a consumed one moves to window position 0.
- R8: Template pattern 7 (codes 28-31) is illegal. Such a bundle issues nothing and blocks later slots in that cycle. When it reaches position 0 it is dropped and counted in consumed_o.
- R9: While br_taken_i is 1, no port is valid, consumed_o is 0 and in_ready_o is 0. In the following cycle the window is empty.
- R10: in_ready_o is 1 when no flush is active and fewer than two bundles remain after this cycle's consumption. A bundle accepted on in_valid_i and in_ready_o is issued from starting in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Bundle offered |
| in_ready_o | output | 1 | Bundle can be taken this cycle |
| in_tmpl_i | input | 5 | Template code of offered bundle |
| in_slots_i | input | 48 | Three slot payloads, slot 0 in the low bits |
| br_taken_i | input | 1 | Taken branch: flush the window |
| port_vld_o | output | 9 | Per-port issue valid |
| port_ins_o | output | 144 | Per-port payload, port p at bits [16p+15:16p] |
| port_org_o | output | 27 | Per-port origin slot index, port p at bits [3p+2:3p] |
| consumed_o | output | 2 | Bundles leaving the window this cycle |

## Verification
A corrupted done mask or window shift shows at the ports in the very next cycle. The symptom is a duplicate or missing issue, or an origin index that points at the wrong window position, because origins are renumbered whenever a bundle leaves. A wrong per-type counter makes a held instruction appear in the same cycle as the instruction that exhausted its type, or makes a later-typed slot jump ahead of a held one. Both are visible in the port mask of the cycle in which they occur. Stale state after a flush shows as issues from the old window in the first cycle after the new bundle loads.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int WIN    = 2;
  localparam int SLOTS  = 3;
  localparam int TMPL_W = 5;
  localparam int ORG_W  = 3;

  localparam logic [1:0] U_INT = 2'd0;
  localparam logic [1:0] U_FP  = 2'd1;
  localparam logic [1:0] U_MEM = 2'd2;
  localparam logic [1:0] U_BR  = 2'd3;

  typedef struct packed {
    logic                   legal;
    logic [SLOTS-1:0][1:0]  kind;
    logic [SLOTS-1:0]       stop;
  } tmpl_t;
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/disp_tmpl_dec.sv
module disp_tmpl_dec
  import disp_pkg::*;
(
  input  logic [TMPL_W-1:0] code_i,
  output tmpl_t             info_o
);
  always_comb begin
    info_o.legal = 1'b1;
    // packed order: {slot2, slot1, slot0}
    case (code_i[4:2])
      3'd0:    info_o.kind = {U_INT, U_INT, U_MEM};
      3'd1:    info_o.kind = {U_INT, U_MEM, U_MEM};
      3'd2:    info_o.kind = {U_INT, U_FP,  U_MEM};
      3'd3:    info_o.kind = {U_BR,  U_INT, U_MEM};
      3'd4:    info_o.kind = {U_BR,  U_BR,  U_MEM};
      3'd5:    info_o.kind = {U_BR,  U_BR,  U_BR };
      3'd6:    info_o.kind = {U_FP,  U_MEM, U_MEM};
      default: begin
        info_o.kind  = {U_MEM, U_MEM, U_MEM};
        info_o.legal = 1'b0;
      end
    endcase
    case (code_i[1:0])
      2'd1:    info_o.stop = 3'b001;
      2'd2:    info_o.stop = 3'b010;
      2'd3:    info_o.stop = 3'b100;
      default: info_o.stop = 3'b000;
    endcase
  end
endmodule

// File: rtl/disp_select.sv
module disp_select
  import disp_pkg::*;
#(
  parameter  int IW        = 16,
  parameter  int N_INT     = 2,
  parameter  int N_FP      = 2,
  parameter  int N_MEM     = 2,
  parameter  int N_BR      = 3,
  parameter  int MAX_ISSUE = 6,
  localparam int NP        = N_INT + N_FP + N_MEM + N_BR,
  localparam int PW        = $clog2(NP)
) (
  input  logic                             hold_i,
  input  logic [WIN-1:0]                   win_vld_i,
  input  tmpl_t [WIN-1:0]                  info_i,
  input  logic [WIN-1:0][SLOTS-1:0]        done_i,
  input  logic [WIN-1:0][SLOTS-1:0][IW-1:0] instr_i,
  output logic [NP-1:0]                    vld_o,
  output logic [NP-1:0][IW-1:0]            ins_o,
  output logic [NP-1:0][ORG_W-1:0]         org_o,
  output logic [WIN-1:0][SLOTS-1:0]        take_o
);
  function automatic int unit_cap(input logic [1:0] u);
    case (u)
      U_INT:   return N_INT;
      U_FP:    return N_FP;
      U_MEM:   return N_MEM;
      default: return N_BR;
    endcase
  endfunction

  function automatic int unit_base(input logic [1:0] u);
    case (u)
      U_INT:   return 0;
      U_FP:    return N_INT;
      U_MEM:   return N_INT + N_FP;
      default: return N_INT + N_FP + N_MEM;
    endcase
  endfunction

  int          used [4];
  int          n_iss;
  logic [1:0]  ut;
  logic [PW-1:0] pidx;
  logic        halt;

  // walk slots oldest first; halt on first hold, stop mark or bad bundle
  always_comb begin
    halt  = hold_i;
    n_iss = 0;
    ut    = U_INT;
    pidx  = '0;
    for (int k = 0; k < 4; k++) used[k] = 0;
    vld_o  = '0;
    ins_o  = '0;
    org_o  = '0;
    take_o = '0;
    for (int b = 0; b < WIN; b++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (!halt && !done_i[b][s]) begin
          if (!win_vld_i[b] || !info_i[b].legal) begin
            halt = 1'b1;
          end else begin
            ut = info_i[b].kind[s];
            if (n_iss >= MAX_ISSUE || used[ut] >= unit_cap(ut)) begin
              halt = 1'b1;
            end else begin
              pidx         = PW'(unit_base(ut) + used[ut]);
              vld_o[pidx]  = 1'b1;
              ins_o[pidx]  = instr_i[b][s];
              org_o[pidx]  = ORG_W'(b * SLOTS + s);
              take_o[b][s] = 1'b1;
              used[ut]     = used[ut] + 1;
              n_iss        = n_iss + 1;
              if (info_i[b].stop[s]) halt = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bundle_disperser.sv
module bundle_disperser
  import disp_pkg::*;
#(
  parameter  int IW        = 16,
  parameter  int N_INT     = 2,
  parameter  int N_FP      = 2,
  parameter  int N_MEM     = 2,
  parameter  int N_BR      = 3,
  parameter  int MAX_ISSUE = 6,
  localparam int NP        = N_INT + N_FP + N_MEM + N_BR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [TMPL_W-1:0]     in_tmpl_i,
  input  logic [SLOTS*IW-1:0]   in_slots_i,
  input  logic                  br_taken_i,
  output logic [NP-1:0]         port_vld_o,
  output logic [NP*IW-1:0]      port_ins_o,
  output logic [NP*ORG_W-1:0]   port_org_o,
  output logic [1:0]            consumed_o
);
  logic rst_n_int;

  logic [WIN-1:0]                    w_vld_q,  w_vld_d;
  logic [WIN-1:0][SLOTS-1:0]         w_done_q, w_done_d;
  logic [WIN-1:0][TMPL_W-1:0]        w_code_q, w_code_d;
  logic [WIN-1:0][SLOTS-1:0][IW-1:0] w_ins_q,  w_ins_d;
  tmpl_t [WIN-1:0]                   w_info;

  logic [NP-1:0][IW-1:0]     sel_ins;
  logic [NP-1:0][ORG_W-1:0]  sel_org;
  logic [WIN-1:0][SLOTS-1:0] take;
  logic [WIN-1:0]            fin;
  logic [1:0]                n_pop, n_rem;
  logic                      accept, pay_en;

  disp_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  for (genvar g = 0; g < WIN; g++) begin : g_dec
    disp_tmpl_dec i_dec (.code_i(w_code_q[g]), .info_o(w_info[g]));
  end

  disp_select #(
    .IW(IW), .N_INT(N_INT), .N_FP(N_FP), .N_MEM(N_MEM), .N_BR(N_BR),
    .MAX_ISSUE(MAX_ISSUE)
  ) i_select (
    .hold_i    (br_taken_i),
    .win_vld_i (w_vld_q),
    .info_i    (w_info),
    .done_i    (w_done_q),
    .instr_i   (w_ins_q),
    .vld_o     (port_vld_o),
    .ins_o     (sel_ins),
    .org_o     (sel_org),
    .take_o    (take)
  );

  assign port_ins_o = sel_ins;
  assign port_org_o = sel_org;

  // a bundle leaves when all slots are done; an illegal head leaves untouched
  always_comb begin
    fin[0] = w_vld_q[0] && !br_taken_i &&
             (!w_info[0].legal || (&(w_done_q[0] | take[0])));
    fin[1] = fin[0] && w_vld_q[1] && w_info[1].legal &&
             (&(w_done_q[1] | take[1]));
  end

  assign n_pop      = {1'b0, fin[0]} + {1'b0, fin[1]};
  assign n_rem      = {1'b0, w_vld_q[0]} + {1'b0, w_vld_q[1]} - n_pop;
  assign in_ready_o = !br_taken_i && (n_rem < 2'd2);
  assign accept     = in_valid_i && in_ready_o;
  assign pay_en     = accept || fin[0];
  assign consumed_o = n_pop;

  always_comb begin
    w_vld_d  = w_vld_q;
    w_code_d = w_code_q;
    w_ins_d  = w_ins_q;
    w_done_d = w_done_q | take;
    if (br_taken_i) begin
      w_vld_d  = '0;
      w_done_d = '0;
    end else begin
      if (fin[1]) begin
        w_vld_d  = '0;
        w_done_d = '0;
      end else if (fin[0]) begin
        w_vld_d     = {1'b0, w_vld_q[1]};
        w_code_d[0] = w_code_q[1];
        w_ins_d[0]  = w_ins_q[1];
        w_done_d[0] = w_done_q[1] | take[1];
        w_done_d[1] = '0;
      end
      if (accept) begin
        w_vld_d[n_rem[0]]  = 1'b1;
        w_code_d[n_rem[0]] = in_tmpl_i;
        w_ins_d[n_rem[0]]  = in_slots_i;
        w_done_d[n_rem[0]] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      w_vld_q  <= '0;
      w_done_q <= '0;
    end else begin
      w_vld_q  <= w_vld_d;
      w_done_q <= w_done_d;
    end
  end

  // payload registers: no reset, qualified by valid bits
  always_ff @(posedge clk) begin
    if (pay_en) begin
      w_code_q <= w_code_d;
      w_ins_q  <= w_ins_d;
    end
  end
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int NP        = 9,
  parameter int MAX_ISSUE = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_taken_i,
  input logic            in_ready_o,
  input logic [NP-1:0]   port_vld_o,
  input logic [NP*3-1:0] port_org_o,
  input logic [1:0]      consumed_o
);
  p_issue_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_vld_o) <= MAX_ISSUE);

  p_consume_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    consumed_o <= 2'd2);

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i |-> (port_vld_o == '0) && (consumed_o == 2'd0));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i |=> (port_vld_o == '0));

  p_ready_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i |-> !in_ready_o);

  for (genvar p = 0; p < NP; p++) begin : g_org
    p_origin_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      port_vld_o[p] |-> (port_org_o[p*3 +: 3] < 3'd6));
  end
endmodule

bind bundle_disperser disp_checker #(.NP(NP), .MAX_ISSUE(MAX_ISSUE)) i_disp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .br_taken_i (br_taken_i),
  .in_ready_o (in_ready_o),
  .port_vld_o (port_vld_o),
  .port_org_o (port_org_o),
  .consumed_o (consumed_o)
);

// File: tb/test_bundle_disperser.sv
`timescale 1ns/1ps
module test_bundle_disperser;
  localparam int IW = 16;
  localparam int NP = 9;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, in_ready, br_taken;
  logic [4:0]         in_tmpl;
  logic [3*IW-1:0]    in_slots;
  logic [NP-1:0]      port_vld;
  logic [NP*IW-1:0]   port_ins;
  logic [NP*3-1:0]    port_org;
  logic [1:0]         consumed;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  bundle_disperser i_bundle_disperser (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_tmpl_i(in_tmpl), .in_slots_i(in_slots), .br_taken_i(br_taken),
    .port_vld_o(port_vld), .port_ins_o(port_ins), .port_org_o(port_org),
    .consumed_o(consumed)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] tc(int pat, int stp);
    return 5'(pat * 4 + stp);
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(logic [4:0] code, logic [15:0] base);
    chk("R10", "in_ready before load", 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    in_tmpl  = code;
    in_slots = {base + 16'd2, base + 16'd1, base};
    step();
    in_valid = 1'b0;
  endtask

  task automatic chk_out(string req, logic [8:0] vld, int cons);
    chk(req, "port valid mask", 32'(port_vld), 32'(vld));
    chk(req, "consumed", 32'(consumed), 32'(cons));
  endtask

  task automatic chk_port(string req, int p, int org, logic [15:0] ins);
    chk(req, $sformatf("port%0d origin", p), 32'(port_org[p*3 +: 3]), 32'(org));
    chk(req, $sformatf("port%0d payload", p), 32'(port_ins[p*IW +: IW]), 32'(ins));
  endtask

  task automatic t_reset();
    chk_out("R1", 9'h000, 0);
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_single();
    push(tc(0, 0), 16'h1100);               // M,I,I
    chk_out("R2", 9'h013, 1);
    chk_port("R2", 4, 0, 16'h1100);
    chk_port("R2", 0, 1, 16'h1101);
    chk_port("R2", 1, 2, 16'h1102);
    step();
    chk_out("R7", 9'h000, 0);
  endtask

  task automatic t_branch_ports();
    push(tc(5, 0), 16'h1500);               // B,B,B
    chk_out("R2", 9'h1C0, 1);
    chk_port("R2", 6, 0, 16'h1500);
    chk_port("R2", 8, 2, 16'h1502);
    step();
  endtask

  task automatic t_type_limit();
    push(tc(0, 1), 16'h2100);               // M | I,I
    chk_out("R5", 9'h010, 0);
    push(tc(1, 0), 16'h2200);               // M,M,I
    chk_out("R3", 9'h033, 1);
    chk_port("R3", 0, 1, 16'h2101);
    chk_port("R3", 1, 2, 16'h2102);
    chk_port("R3", 4, 3, 16'h2200);
    chk_port("R3", 5, 4, 16'h2201);
    step();
    chk_out("R3", 9'h001, 1);               // held I retried, origin renumbered
    chk_port("R7", 0, 2, 16'h2202);
    step();
    chk_out("R3", 9'h000, 0);
  endtask

  task automatic t_in_order();
    push(tc(0, 1), 16'h3100);
    chk_out("R4", 9'h010, 0);
    push(tc(3, 0), 16'h3200);               // M,I,B
    chk_out("R4", 9'h013, 1);               // B held behind blocked I
    chk_port("R4", 4, 3, 16'h3200);
    step();
    chk_out("R4", 9'h041, 1);
    chk_port("R4", 0, 1, 16'h3201);
    chk_port("R4", 6, 2, 16'h3202);
    step();
  endtask

  task automatic t_stop();
    push(tc(0, 1), 16'h4100);
    chk_out("R5", 9'h010, 0);
    push(tc(6, 1), 16'h4200);               // M | M,F
    chk_out("R5", 9'h013, 1);               // M1 free but after stop
    chk_port("R5", 4, 3, 16'h4200);
    step();
    chk_out("R5", 9'h014, 1);
    chk_port("R5", 4, 1, 16'h4201);
    chk_port("R5", 2, 2, 16'h4202);
    step();
  endtask

  task automatic t_dual_pop();
    push(tc(0, 1), 16'h5100);
    chk_out("R7", 9'h010, 0);
    push(tc(5, 0), 16'h5200);
    chk_out("R7", 9'h1C3, 2);
    chk("R6", "issue count within cap", 32'($countones(port_vld) <= 6), 32'd1);
    chk_port("R7", 6, 3, 16'h5200);
    chk_port("R7", 8, 5, 16'h5202);
    step();
    chk_out("R7", 9'h000, 0);
  endtask

  task automatic t_illegal();
    push(tc(7, 0), 16'h6100);
    chk_out("R8", 9'h000, 1);
    step();
    chk_out("R8", 9'h000, 0);
    push(tc(0, 0), 16'h6200);
    chk_out("R8", 9'h013, 1);
    chk_port("R8", 4, 0, 16'h6200);
    step();
  endtask

  task automatic t_flush();
    push(tc(0, 1), 16'h7100);
    chk_out("R9", 9'h010, 0);
    br_taken = 1'b1;
    #1;
    chk_out("R9", 9'h000, 0);
    chk("R9", "in_ready during flush", 32'(in_ready), 32'd0);
    step();
    br_taken = 1'b0;
    #1;
    chk_out("R9", 9'h000, 0);
    chk("R10", "in_ready after flush", 32'(in_ready), 32'd1);
    push(tc(5, 0), 16'h7200);
    chk_out("R9", 9'h1C0, 1);
    chk_port("R9", 6, 0, 16'h7200);
    step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_tmpl  = '0;
    in_slots = '0;
    br_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_single();
    t_branch_ports();
    t_type_limit();
    t_in_order();
    t_stop();
    t_dual_pop();
    t_illegal();
    t_flush();
    finished = 1;
    summary();
    $finish;
  end
endmodule